// File: doc/BRIEF.md
# ADPCM Codeword Serial Port

This block carries one transcoder channel's ADPCM codeword over a single-wire serial link in both directions. The codeword is 2, 3, 4 or 5 bits wide, and a two-bit mode select chooses the width. A frame enable marks the window in which the link is active. A bit clock paces the bits inside that window. Every input is sampled on the system clock, and the frame enable and bit clock are turned into edge events inside the block.

The receive side samples the serial input on each falling edge of the bit clock while the frame is open. When the frame closes, it takes the most recent bits as the codeword. The transmit side latches a parallel codeword when the frame opens and drives it out most significant bit first. If more bit clocks arrive than the codeword has bits, the word repeats.

A state machine controls the port. It has three states.
- S_WAKE is entered from reset. The output is high impedance and the receiver is ignored. The transition WAKE_TO_IDLE is taken once the frame enable is sampled low.
- S_IDLE means the frame is closed. The transition IDLE_TO_OPEN is taken on a rising edge of the frame enable.
- S_OPEN means the frame is open. The transition OPEN_TO_IDLE is taken on a falling edge of the frame enable.

Top module: `adpcm_serial_port`

## Requirements
- R1: The codeword width N follows the mode select: 2'b00 gives 4 bits, 2'b01 gives 3, 2'b10 gives 2 and 2'b11 gives 5.
- R2: In the clock cycle after a rising edge of frame_en is sampled, ser_oe is 1. ser_pad then carries bit N-1 of the tx_word that was sampled at that edge.
- R3: Each bit clock rising edge sampled while the frame is open moves ser_pad to the next lower codeword bit.
- R4: After bit 0, the next bit clock rising edge returns ser_pad to bit N-1, so the word repeats while the frame stays open.
- R5: ser_in is sampled on bit clock falling edges while the frame is open. One cycle after the frame_en falling edge is sampled, rx_valid is 1 for exactly one cycle. rx_word then holds the last N sampled bits right-justified, with the most recent bit at bit 0.
- R6: rx_word bits at positions N and above are always 0.
- R7: If fewer than N bits arrived in the frame, the missing older positions of rx_word read 0.
- R8: While the frame is closed, ser_oe is 0 and ser_pad is high impedance.
- R9: After reset, ser_oe stays 0 and no receive word is produced until frame_en has been sampled low.
- R10: The transmit width is taken from the mode at the frame's rising edge. The receive width is taken from the mode at the frame's falling edge.
- R11: A change of tx_word while the frame is open has no effect on ser_pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Codeword width select |
| frame_en | input | 1 | Frame enable, high while the link is active |
| bit_clk | input | 1 | Serial bit clock, idle high |
| ser_in | input | 1 | Serial receive data |
| tx_word | input | 5 | Parallel codeword to transmit, right-justified |
| ser_pad | output | 1 | Serial transmit data, high impedance when not driven |
| ser_oe | output | 1 | High while ser_pad is driven |
| rx_word | output | 5 | Received codeword, right-justified |
| rx_valid | output | 1 | One-cycle strobe when rx_word is updated |

## Verification
The assertions assume three things about the inputs:
- frame_en and bit_clk are synchronous to clk and each level lasts at least one clock cycle.
- A bit clock edge never falls in the same cycle as a frame edge.
- The bit clock is high whenever the frame opens or closes.

The stimulus meets these rules by construction. Every frame opens and closes with the bit clock high, and each bit clock phase lasts three system clocks. Random frames vary the mode, the codeword, the received bits and the number of bit clocks. Directed frames switch the mode or the codeword partway through a frame, and one case holds the frame enable high across reset release.

// File: rtl/adpcm_sp_pkg.sv
package adpcm_sp_pkg;

    localparam int MAX_W  = 5;
    localparam int WID_W  = $clog2(MAX_W + 1);
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        S_WAKE = 2'd0,
        S_IDLE = 2'd1,
        S_OPEN = 2'd2
    } sp_state_e;

    function automatic logic [WID_W-1:0] cw_width(input logic [MODE_W-1:0] m);
        logic [WID_W-1:0] w;
        unique case (m)
            2'b00:   w = WID_W'(4);
            2'b01:   w = WID_W'(3);
            2'b10:   w = WID_W'(2);
            default: w = WID_W'(5);
        endcase
        return w;
    endfunction

    function automatic logic [MAX_W-1:0] cw_mask(input logic [WID_W-1:0] w);
        logic [MAX_W-1:0] m;
        for (int i = 0; i < MAX_W; i++) begin
            m[i] = (i < int'(w));
        end
        return m;
    endfunction

endpackage

// File: rtl/sp_edge.sv
module sp_edge #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= RST_VAL[g];
            end else begin
                prev_q[g] <= din[g];
            end
        end
        assign rise[g] = din[g] & ~prev_q[g];
        assign fall[g] = ~din[g] & prev_q[g];
    end

endmodule

// File: rtl/sp_rx_shift.sv
module sp_rx_shift
    import adpcm_sp_pkg::*;
#(
    parameter int W = MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    input  logic             capture,
    input  logic [WID_W-1:0] width,
    output logic [W-1:0]     word,
    output logic             valid
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clear) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                word <= sr_q & cw_mask(width);
            end
        end
    end

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((word & ~cw_mask($past(width))) == '0));

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/sp_tx_ser.sv
module sp_tx_ser
    import adpcm_sp_pkg::*;
#(
    parameter int W = MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     word_in,
    input  logic [WID_W-1:0] width_in,
    input  logic             advance,
    output logic             bit_out
);

    logic [W-1:0]     word_q;
    logic [WID_W-1:0] wid_q;
    logic [WID_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            wid_q  <= WID_W'(1);
            idx_q  <= '0;
        end else if (load) begin
            word_q <= word_in;
            wid_q  <= width_in;
            idx_q  <= width_in - WID_W'(1);
        end else if (advance) begin
            if (idx_q == '0) begin
                idx_q <= wid_q - WID_W'(1);
            end else begin
                idx_q <= idx_q - WID_W'(1);
            end
        end
    end

    assign bit_out = word_q[idx_q];

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_out == $past(word_in[width_in - WID_W'(1)])));

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < wid_q);

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && idx_q == '0) |=> (idx_q == $past(wid_q) - WID_W'(1)));

endmodule

// File: rtl/adpcm_serial_port.sv
module adpcm_serial_port
    import adpcm_sp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_sel,
    input  logic                frame_en,
    input  logic                bit_clk,
    input  logic                ser_in,
    input  logic [MAX_W-1:0]    tx_word,
    output logic                ser_pad,
    output logic                ser_oe,
    output logic [MAX_W-1:0]    rx_word,
    output logic                rx_valid
);

    localparam int EDGE_N = 2;
    localparam int I_FRAME = 0;
    localparam int I_BCLK  = 1;

    sp_state_e state_q, state_d;

    logic [EDGE_N-1:0] ev_rise, ev_fall;
    logic tx_load, tx_adv, rx_clear, rx_shift, rx_cap, tx_bit;
    logic [WID_W-1:0] cur_width;

    sp_edge #(.N(EDGE_N), .RST_VAL(2'b10)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bit_clk, frame_en}),
        .rise (ev_rise),
        .fall (ev_fall)
    );

    assign cur_width = cw_width(mode_sel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_WAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: WAKE_TO_IDLE, IDLE_TO_OPEN, OPEN_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAKE: if (!frame_en)          state_d = S_IDLE;
            S_IDLE: if (ev_rise[I_FRAME])   state_d = S_OPEN;
            S_OPEN: if (ev_fall[I_FRAME])   state_d = S_IDLE;
            default:                        state_d = S_WAKE;
        endcase
    end

    // per-state control outputs
    always_comb begin
        tx_load  = 1'b0;
        tx_adv   = 1'b0;
        rx_clear = 1'b0;
        rx_shift = 1'b0;
        rx_cap   = 1'b0;
        ser_oe   = 1'b0;
        unique case (state_q)
            S_WAKE: begin
            end
            S_IDLE: begin
                tx_load  = ev_rise[I_FRAME];
                rx_clear = ev_rise[I_FRAME];
            end
            S_OPEN: begin
                ser_oe   = 1'b1;
                tx_adv   = ev_rise[I_BCLK] & frame_en;
                rx_shift = ev_fall[I_BCLK] & frame_en;
                rx_cap   = ev_fall[I_FRAME];
            end
            default: begin
            end
        endcase
    end

    sp_tx_ser #(.W(MAX_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .word_in (tx_word),
        .width_in(cur_width),
        .advance (tx_adv),
        .bit_out (tx_bit)
    );

    sp_rx_shift #(.W(MAX_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rx_clear),
        .shift  (rx_shift),
        .din    (ser_in),
        .capture(rx_cap),
        .width  (cur_width),
        .word   (rx_word),
        .valid  (rx_valid)
    );

    assign ser_pad = ser_oe ? tx_bit : 1'bz;

    assert_oe_needs_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> $past(frame_en));

    assert_valid_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!$past(frame_en) && $past(frame_en, 2)));

    assert_wake_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAKE) |-> (!ser_oe && !rx_valid));

    assert_open_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && frame_en && !$past(frame_en)) |=> ser_oe);

endmodule

// File: tb/sim_adpcm_serial_port.sv
module sim_adpcm_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       frame_en = 1'b0;
    logic       bit_clk = 1'b1;
    logic       ser_in = 1'b0;
    logic [4:0] tx_word = 5'd0;
    wire        ser_pad;
    logic       ser_oe;
    logic [4:0] rx_word;
    logic       rx_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adpcm_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .frame_en(frame_en),
        .bit_clk(bit_clk), .ser_in(ser_in), .tx_word(tx_word),
        .ser_pad(ser_pad), .ser_oe(ser_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    function automatic int wid(input logic [1:0] m);
        case (m)
            2'b00: return 4;
            2'b01: return 3;
            2'b10: return 2;
            default: return 5;
        endcase
    endfunction

    function automatic logic exp_tx(input logic [4:0] w, input logic [1:0] m, input int k);
        return w[wid(m) - 1 - (k % wid(m))];
    endfunction

    function automatic logic [4:0] exp_rx(input logic [15:0] b, input int n, input logic [1:0] m);
        logic [4:0] sr = 5'd0;
        for (int i = 0; i < n; i++) sr = {sr[3:0], b[i]};
        for (int i = 0; i < 5; i++) if (i >= wid(m)) sr[i] = 1'b0;
        return sr;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one frame: mode at open / at close, word at open / mid-frame, n bit clocks
    task automatic run_frame(input logic [1:0] m_open, input logic [1:0] m_close,
                             input logic [4:0] w_open, input logic [4:0] w_mid,
                             input int n, input logic [15:0] rxb);
        mode_sel = m_open;
        tx_word  = w_open;
        bit_clk  = 1'b1;
        frame_en = 1'b1;
        tick(1);
        chk(ser_oe == 1'b1, "R2 oe after open", int'(ser_oe), 1);
        tick(2);
        tx_word = w_mid;  // R11: ignored until next open
        for (int k = 0; k < n; k++) begin
            chk(ser_pad === exp_tx(w_open, m_open, k),
                (k == 0) ? "R2 msb first" : ((k % wid(m_open)) == 0 ? "R4 wrap" : "R3 next bit R11"),
                int'(ser_pad), int'(exp_tx(w_open, m_open, k)));
            bit_clk = 1'b0;
            ser_in  = rxb[k];
            tick(3);
            bit_clk = 1'b1;
            tick(3);
        end
        mode_sel = m_close;  // R10: receive width from close
        tick(1);
        frame_en = 1'b0;
        tick(1);
        chk(rx_valid == 1'b1, "R5 valid", int'(rx_valid), 1);
        chk(rx_word == exp_rx(rxb, n, m_close), "R5 R6 R7 R10 rx word",
            int'(rx_word), int'(exp_rx(rxb, n, m_close)));
        chk(ser_oe == 1'b0, "R8 closed oe", int'(ser_oe), 0);
        tick(1);
        chk(rx_valid == 1'b0, "R5 one-cycle valid", int'(rx_valid), 0);
        tick(2);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h0AD0_5EED);
        // R9: frame_en high across reset release
        frame_en = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk(ser_oe == 1'b0 && rx_valid == 1'b0 && rx_word == 5'd0, "R9 reset state",
            int'(ser_oe), 0);
        for (int i = 0; i < 4; i++) begin
            bit_clk = 1'b0; ser_in = 1'b1; tick(3);
            bit_clk = 1'b1; tick(3);
            chk(ser_oe == 1'b0, "R9 no drive in wake R8", int'(ser_oe), 0);
        end
        frame_en = 1'b0;
        tick(1);
        chk(rx_valid == 1'b0, "R9 no capture in wake", int'(rx_valid), 0);
        tick(1);
        chk(rx_valid == 1'b0 && rx_word == 5'd0, "R9 rx untouched", int'(rx_word), 0);
        tick(2);

        // directed: each mode R1, wrap cases R4
        run_frame(2'b00, 2'b00, 5'b01011, 5'b01011, 8, 16'hA5C3);
        run_frame(2'b11, 2'b11, 5'b10110, 5'b10110, 7, 16'h3C5A);
        run_frame(2'b01, 2'b01, 5'b00101, 5'b00101, 6, 16'h0F0F);
        run_frame(2'b10, 2'b10, 5'b00010, 5'b00010, 5, 16'hFFFF);
        // R7: too few bits
        run_frame(2'b11, 2'b11, 5'b11111, 5'b11111, 2, 16'h0003);
        // R10: mode change mid-frame, R11: word change mid-frame
        run_frame(2'b10, 2'b11, 5'b00001, 5'b11110, 9, 16'h1F3D);
        run_frame(2'b11, 2'b10, 5'b10101, 5'b01010, 6, 16'hFFFF);

        for (int f = 0; f < 60; f++) begin
            logic [1:0] mo, mc;
            logic [4:0] wo, wm;
            int n;
            logic [15:0] b;
            mo = 2'($urandom());
            mc = ($urandom() % 4 == 0) ? 2'($urandom()) : mo;
            wo = 5'($urandom());
            wm = ($urandom() % 3 == 0) ? 5'($urandom()) : wo;
            n  = 1 + int'($urandom() % 12);
            b  = 16'($urandom());
            run_frame(mo, mc, wo, wm, n, b);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule